// File: doc/BRIEF.md
# Bit-Reversed SPI Register Access Engine

This block is the host side of a serial link to an isolated data-converter peripheral whose registers are reached one at a time. A client hands it one request at a time on a valid/ready handshake. A request carries a 5-bit register address, a direction flag and, for a write, a 10-bit value. The engine turns the request into 16-bit serial frames. It generates the serial clock from the system clock through a parameterised divider. When a read finishes, it returns the 10-bit result together with a one-cycle completion pulse.

Each frame packs the address into bits 15:11, the write flag into bit 10 and the payload into bits 9:0. Frames travel least significant bit first in both directions, which is the reverse of a conventional MSB-first shifter. A write fits in one frame. A read takes two frames. The first is a command frame that carries only the address. Chip select is then released for a programmable number of serial-clock periods. A second frame follows, and the peripheral's answer is clocked in during it. The serial lines follow SPI mode 0: the clock idles low, outgoing data moves on falling edges and incoming data is sampled on rising edges.

Top module: `spi_regx_engine`

## Requirements
- R1: A write request produces exactly one 16-bit frame under a single chip-select assertion. The frame holds the address in bits 15:11, a 1 in bit 10 and the write value in bits 9:0.
- R2: Frames on `mosi` are sent bit 0 first and bit 15 last, so the n-th bit clocked out is bit n-1 of the logical word.
- R3: A read request produces two frames. The first holds the address in bits 15:11 and zeros in bits 10:0. The second frame carries all-zero data on `mosi`.
- R4: During the second frame of a read, `miso` is sampled bit 0 first. `rd_data` receives bits 9:0 of the reassembled word, and bits 15:10 of that word are discarded.
- R5: Between the two frames of a read, `cs_n` stays high for 2*GAP_SCLK*CLK_HALF system-clock cycles, which is GAP_SCLK serial-clock periods.
- R6: `sclk` has a period of 2*CLK_HALF system-clock cycles and toggles only while `cs_n` is low. It is low whenever `cs_n` is high, and `mosi` does not change while `sclk` is high.
- R7: `req_ready` falls in the cycle after a request is accepted and stays low until the completion cycle. `done` is a one-cycle pulse and coincides with `req_ready` returning high. A request presented while the engine is busy starts no frame and is dropped.
- R8: A synchronous active-high reset, including one applied in the middle of a frame, returns the engine to idle. After reset `cs_n` is 1, `sclk` is 0, `req_ready` is 1, `done` is 0 and `rd_data` is 0.
- R9: The full 5-bit address range is carried unchanged. This includes the verification copies at a primary address plus 0x10 (0x10 to 0x1C).
- R10: `rd_data` changes only in the completion cycle of a read. A write completion leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W (5) | Register address |
| req_wdata | input | DATA_W (10) | Value to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W (10) | Result of the last completed read |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bound checker enforces the following properties on every cycle:
- the idle line levels;
- the serial clock staying low while chip select is high;
- `mosi` holding steady through each high phase of `sclk`;
- the handshake timing from acceptance to completion, and `done` lasting a single cycle;
- `rd_data` changing only when `done` is high;
- the minimum chip-select gap inside a read.

Other properties can only be shown by the bench's scenarios. These are the bit content and bit order of each frame, the reassembly of the LSB-first response, and the discarding of its upper six bits. The same applies to the handling of verification-copy addresses, to busy-time requests being dropped, and to recovery from a reset in mid-frame. The bench shows them through a peripheral model that decodes every frame and answers reads.

// File: rtl/spi_regx_pkg.sv
package spi_regx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } eng_state_t;
endpackage

// File: rtl/spi_regx_tick.sv
// Half-period strobe for the serial clock: one pulse every HALF system cycles while run is high.
module spi_regx_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   generate
      if (HALF < 1) begin : g_bad
         $error("spi_regx_tick: HALF must be at least 1");
      end
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || !run)                cnt_q <= '0;
            else if (cnt_q == CW'(HALF-1))  cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CW'(HALF-1));
      end
   endgenerate
endmodule

// File: rtl/spi_regx_shift.sv
// Frame shifter; LSB_FIRST selects the serial bit order for both directions.
module spi_regx_shift #(
   parameter int FW        = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [FW-1:0] load_word,
   input  logic          advance,
   input  logic          capture,
   input  logic          miso,
   output logic          mosi,
   output logic [FW-1:0] rx_word
);
   logic [FW-1:0] tx_q;
   logic [FW-1:0] rx_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk) begin
            if (rst)          tx_q <= '0;
            else if (load)    tx_q <= load_word;
            else if (advance) tx_q <= {1'b0, tx_q[FW-1:1]};
         end
         always_ff @(posedge clk) begin
            if (rst || load)  rx_q <= '0;
            else if (capture) rx_q <= {miso, rx_q[FW-1:1]};
         end
         assign mosi = tx_q[0];
      end else begin : g_msb
         always_ff @(posedge clk) begin
            if (rst)          tx_q <= '0;
            else if (load)    tx_q <= load_word;
            else if (advance) tx_q <= {tx_q[FW-2:0], 1'b0};
         end
         always_ff @(posedge clk) begin
            if (rst || load)  rx_q <= '0;
            else if (capture) rx_q <= {rx_q[FW-2:0], miso};
         end
         assign mosi = tx_q[FW-1];
      end
   endgenerate

   assign rx_word = rx_q;
endmodule

// File: rtl/spi_regx_engine.sv
module spi_regx_engine
   import spi_regx_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 10,
   parameter int CLK_HALF  = 2,
   parameter int GAP_SCLK  = 2,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   localparam int FRAME_W   = ADDR_W + 1 + DATA_W;
   localparam int BIT_W     = $clog2(FRAME_W);
   localparam int GAP_TICKS = 2 * GAP_SCLK;
   localparam int GAP_W     = $clog2(GAP_TICKS + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("spi_regx_engine: field widths must be positive");
      end
      if (GAP_SCLK < 1) begin : g_bad_gap
         $error("spi_regx_engine: GAP_SCLK must be at least 1");
      end
   endgenerate

   eng_state_t         state_q;
   logic               is_read_q;
   logic               resp_q;
   logic [BIT_W-1:0]   bit_q;
   logic [GAP_W-1:0]   gap_q;
   logic               sclk_q;
   logic               cs_n_q;
   logic               done_q;
   logic [DATA_W-1:0]  rdata_q;

   logic               tick;
   logic               accept;
   logic               gap_end;
   logic               last_fall;
   logic               load;
   logic [FRAME_W-1:0] load_word;
   logic               advance;
   logic               capture;
   logic [FRAME_W-1:0] rx_word;

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign gap_end   = (state_q == ST_GAP) && tick && (gap_q == GAP_W'(GAP_TICKS-1));
   assign last_fall = (state_q == ST_FRAME) && tick && sclk_q &&
                      (bit_q == BIT_W'(FRAME_W-1));
   assign load      = accept || gap_end;
   assign load_word = accept ? {req_addr, req_write, (req_write ? req_wdata : DATA_W'(0))}
                             : FRAME_W'(0);
   assign advance   = (state_q == ST_FRAME) && tick && sclk_q && !last_fall;
   assign capture   = (state_q == ST_FRAME) && tick && !sclk_q;

   spi_regx_tick #(.HALF(CLK_HALF)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (state_q != ST_IDLE),
      .tick (tick)
   );

   spi_regx_shift #(.FW(FRAME_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_word (load_word),
      .advance   (advance),
      .capture   (capture),
      .miso      (miso),
      .mosi      (mosi),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         is_read_q <= 1'b0;
         resp_q    <= 1'b0;
         bit_q     <= '0;
         gap_q     <= '0;
         sclk_q    <= 1'b0;
         cs_n_q    <= 1'b1;
         done_q    <= 1'b0;
         rdata_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q   <= ST_FRAME;
                  is_read_q <= !req_write;
                  resp_q    <= 1'b0;
                  bit_q     <= '0;
                  cs_n_q    <= 1'b0;
               end
            end
            ST_FRAME: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (last_fall) begin
                        cs_n_q <= 1'b1;
                        bit_q  <= '0;
                        if (is_read_q && !resp_q) begin
                           state_q <= ST_GAP;
                           gap_q   <= '0;
                        end else begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                           if (is_read_q) rdata_q <= rx_word[DATA_W-1:0];
                        end
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_end) begin
                     state_q <= ST_FRAME;
                     resp_q  <= 1'b1;
                     cs_n_q  <= 1'b0;
                  end else begin
                     gap_q <= gap_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign done      = done_q;
   assign rd_data   = rdata_q;
   assign sclk      = sclk_q;
   assign cs_n      = cs_n_q;
endmodule

// File: rtl/spi_regx_chk.sv
module spi_regx_chk #(
   parameter int DATA_W   = 10,
   parameter int CLK_HALF = 2,
   parameter int GAP_SCLK = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic [DATA_W-1:0] rd_data,
   input logic              sclk,
   input logic              cs_n,
   input logic              mosi
);
   localparam int MIN_GAP = 2 * GAP_SCLK * CLK_HALF;

   logic [15:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (rst || !cs_n)            hi_cnt <= '0;
      else if (!req_ready && hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
   end

   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (cs_n && !sclk)); // R8

   AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> !sclk); // R6

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk)) |-> $stable(mosi)); // R6

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> (!req_ready && !cs_n)); // R7

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R7

   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> req_ready); // R7

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(rd_data)); // R10

   AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
      ($fell(cs_n) && hi_cnt != 16'd0) |-> (int'(hi_cnt) >= MIN_GAP)); // R5
endmodule

bind spi_regx_engine spi_regx_chk #(
   .DATA_W   (DATA_W),
   .CLK_HALF (CLK_HALF),
   .GAP_SCLK (GAP_SCLK)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .rd_data   (rd_data),
   .sclk      (sclk),
   .cs_n      (cs_n),
   .mosi      (mosi)
);

// File: tb/spi_regx_engine_tb.sv
`timescale 1ns/1ps
module spi_regx_engine_tb;
   localparam int CLK_HALF = 2;
   localparam int GAP_SCLK = 2;
   localparam int EXP_GAP  = 2 * GAP_SCLK * CLK_HALF;
   localparam int EXP_PER  = 2 * CLK_HALF;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [4:0] req_addr  = '0;
   logic [9:0] req_wdata = '0;
   logic       req_ready, done, sclk, cs_n, mosi;
   logic [9:0] rd_data;
   logic       miso_r = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   spi_regx_engine #(.CLK_HALF(CLK_HALF), .GAP_SCLK(GAP_SCLK)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n),
      .mosi(mosi), .miso(miso_r)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- peripheral model ----------------
   logic [9:0]  regs [32];
   logic [9:0]  mdl  [32];
   logic [15:0] frames [$];
   int          fbits  [$];
   logic [15:0] shreg;
   logic [15:0] resp;
   logic        expect_resp = 1'b0;
   int          nbits = 0;
   int          bidx  = 0;

   initial begin
      for (int i = 0; i < 32; i++) begin
         regs[i] = 10'((i * 37 + 5) & 10'h3FF);
         mdl[i]  = 10'((i * 37 + 5) & 10'h3FF);
      end
   end

   always @(negedge cs_n) begin
      nbits  = 0;
      shreg  = '0;
      bidx   = 0;
      miso_r = expect_resp ? resp[0] : 1'b0;
   end

   always @(posedge sclk) if (!cs_n) begin
      if (nbits < 16) shreg[nbits] = mosi;
      nbits++;
   end

   always @(negedge sclk) if (!cs_n) begin
      bidx++;
      miso_r = (expect_resp && bidx < 16) ? resp[bidx] : 1'b0;
   end

   always @(posedge cs_n) if (nbits > 0) begin
      frames.push_back(shreg);
      fbits.push_back(nbits);
      if (expect_resp) expect_resp = 1'b0;
      else if (shreg[10]) regs[shreg[15:11]] = shreg[9:0];
      else begin
         resp = {6'b101101, regs[shreg[15:11]]};
         expect_resp = 1'b1;
      end
      nbits = 0;
   end

   // ---------------- per-cycle monitors ----------------
   int  cyc = 0;
   int  hi_cycles = 0;
   int  last_gap = 0;
   int  last_rise = -1;
   int  period_bad = 0;
   int  mosi_bad = 0;
   logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         chk(!(cs_n && sclk), "R6", "sclk high with cs_n high", int'(sclk), 0);
         if (!cs_n && prev_cs && hi_cycles > 0) last_gap = hi_cycles;
         if (cs_n && !req_ready) hi_cycles++;
         else hi_cycles = 0;
         if (!cs_n && prev_cs) last_rise = -1;
         if (sclk && !prev_sclk) begin
            if (last_rise >= 0 && (cyc - last_rise) != EXP_PER) period_bad++;
            last_rise = cyc;
         end
         if (sclk && prev_sclk && mosi != prev_mosi) mosi_bad++;
      end
      prev_sclk = sclk;
      prev_mosi = mosi;
      prev_cs   = cs_n;
   end

   // ---------------- stimulus tasks ----------------
   task automatic issue(bit wr, logic [4:0] a, logic [9:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R7", "ready after accept", int'(req_ready), 0);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(done && req_ready, "R7", "done with ready", int'(done), 1);
      @(negedge clk);
      chk(!done, "R7", "done one cycle", int'(done), 0);
   endtask

   task automatic do_write(logic [4:0] a, logic [9:0] d, string req);
      logic [9:0] rd_before;
      rd_before = rd_data;
      frames.delete(); fbits.delete();
      issue(1'b1, a, d);
      wait_done();
      mdl[a] = d;
      chk(frames.size() == 1, "R1", "write frame count", frames.size(), 1);
      if (frames.size() >= 1) begin
         chk(frames[0] == {a, 1'b1, d}, "R1 R2", {req, " write frame"},
             int'(frames[0]), int'({a, 1'b1, d}));
         chk(fbits[0] == 16, "R1", "write frame bits", fbits[0], 16);
      end
      chk(rd_data == rd_before, "R10", "rd_data after write",
          int'(rd_data), int'(rd_before));
   endtask

   task automatic do_read(logic [4:0] a, string req);
      frames.delete(); fbits.delete();
      issue(1'b0, a, 10'h3FF);
      wait_done();
      chk(frames.size() == 2, "R3", "read frame count", frames.size(), 2);
      if (frames.size() >= 2) begin
         chk(frames[0] == {a, 11'd0}, "R3 R2", {req, " command frame"},
             int'(frames[0]), int'({a, 11'd0}));
         chk(frames[1] == 16'h0, "R3", "response frame mosi", int'(frames[1]), 0);
      end
      chk(rd_data == mdl[a], "R4", {req, " read data"}, int'(rd_data), int'(mdl[a]));
      chk(last_gap == EXP_GAP, "R5", "cs_n gap cycles", last_gap, EXP_GAP);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(cs_n == 1'b1, "R8", "reset cs_n", int'(cs_n), 1);
      chk(sclk == 1'b0, "R8", "reset sclk", int'(sclk), 0);
      chk(req_ready == 1'b1, "R8", "reset ready", int'(req_ready), 1);
      chk(done == 1'b0, "R8", "reset done", int'(done), 0);
      chk(rd_data == 10'h0, "R8", "reset rd_data", int'(rd_data), 0);

      do_read(5'h07, "R4 preset");
      do_write(5'h03, 10'h155, "R1 alt pattern");
      do_write(5'h0C, 10'h2AA, "R1 alt pattern inverse");
      do_write(5'h19, 10'h3FF, "R9 verification copy");
      do_write(5'h00, 10'h001, "R2 single low bit");
      do_read(5'h03, "R4 after write");
      do_read(5'h0C, "R4 top primary");
      do_read(5'h19, "R9 verification copy");
      do_read(5'h1F, "R9 highest address");
      do_write(5'h10, 10'h200, "R2 single high bit");
      do_read(5'h10, "R9 copy of address 0");

      // R7: a request presented while busy must be dropped
      frames.delete(); fbits.delete();
      issue(1'b0, 5'h05, 10'h0);
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h05; req_wdata = 10'h0AB;
      repeat (3) @(negedge clk);
      chk(!req_ready, "R7", "ready while busy", int'(req_ready), 0);
      req_valid = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      chk(frames.size() == 2, "R7", "frames with busy request", frames.size(), 2);
      chk(rd_data == mdl[5], "R7", "busy request did not write", int'(rd_data), int'(mdl[5]));
      do_read(5'h05, "R7 register untouched");

      // R8: reset in the middle of a frame
      issue(1'b1, 5'h09, 10'h3C3);
      repeat (9) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b1, "R8", "mid-frame reset cs_n", int'(cs_n), 1);
      chk(sclk == 1'b0, "R8", "mid-frame reset sclk", int'(sclk), 0);
      chk(req_ready == 1'b1, "R8", "mid-frame reset ready", int'(req_ready), 1);
      chk(rd_data == 10'h0, "R8", "mid-frame reset rd_data", int'(rd_data), 0);
      @(negedge clk);
      rst = 1'b0;
      expect_resp = 1'b0;
      @(negedge clk);
      do_read(5'h09, "R8 after reset");

      chk(period_bad == 0, "R6", "sclk period violations", period_bad, 0);
      chk(mosi_bad == 0, "R6", "mosi moved while sclk high", mosi_bad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule